// File: doc/BRIEF.md
# SD Host Command Issue Controller

This block is the register-side front end of an SD/MMC host controller. A processor writes a command argument and a command word over a simple word-addressed register port. The block decodes the flags in the command word and hands one command at a time to a card-bus engine through a start/done handshake. The engine does the serial shifting and CRC work on the command line and is outside this block. When the engine reports completion, the block captures the response and records completion and error flags in a raw interrupt status register.

Software issues a command by writing the command word with its load bit set. The load bit reads back as set until the command has been taken, so software can poll it. A command word with the update-clock flag sends nothing to the card. It copies the programmed clock-control settings into the clock outputs that are in use, so a change of clock enable or divider only takes effect through such a command. If a command with a data phase is pending while the card signals busy, it waits until the card is no longer busy.

The interrupt output is the OR of the raw status bits that the mask register enables, gated by a global interrupt enable.

Top module: `sd_cmd_issue`

## Requirements
- R1: Register word addresses are: 0 global control, 1 clock control, 2 command, 3 argument, 4 to 7 response words 0 to 3, 8 interrupt mask, 9 raw interrupt status, 10 status. In the command word, bits [5:0] are the index, bit 6 means a response is expected, bit 7 means a long response, bit 8 means check the response CRC, bit 9 means a data phase, bit 15 means send the initialization sequence, bit 21 means update clock, and bit 31 is the load bit. Writing the command word with bit 31 set makes the command pending. When the command is accepted, bit 31 reads back 0 and `eng_start_o` is high for exactly one cycle, with `eng_index_o` carrying the index and `eng_arg_o` carrying the argument.
- R2: A write to the command register while its bit 31 still reads 1 is ignored, and the pending command word is unchanged.
- R3: An accepted command with bit 21 set never raises `eng_start_o`. It copies clock-control bit 16 to `card_clk_en_o` and clock-control bits [7:0] to `card_clk_div_o`, and it clears bit 31.
- R4: Writes to the clock-control register do not change `card_clk_en_o` or `card_clk_div_o` until an update-clock command is accepted.
- R5: Status bit 9 reflects `card_busy_i`. A pending command with bit 9 set is not started while `card_busy_i` is high, and it starts once `card_busy_i` falls.
- R6: On completion of a command with bit 6 set, response word 0 takes `eng_resp_i[31:0]`. If bit 7 is also set, response words 1 to 3 take the next 32-bit slices in ascending order. Otherwise words 1 to 3 are unchanged. If bit 6 is clear, no response word changes.
- R7: Completion sets raw status bit 2. An engine timeout sets bit 8, a start-bit error sets bit 13, an end-bit error sets bit 15, and a response error sets bit 1.
- R8: An engine CRC error sets raw status bit 6 only if command bit 8 was set. Otherwise it is ignored.
- R9: Writing a 1 to a raw status bit clears that bit. If a clear and a set of the same bit fall in the same cycle, the bit ends up set.
- R10: `irq_o` is high exactly when global-control bit 4 is 1 and at least one bit of (raw status AND mask) is 1.

Interface timing is as follows. A register write takes effect at the clock edge where `reg_we_i` is high, and `reg_rdata_o` follows `reg_addr_i` combinationally. A pending command is accepted at the next clock edge, so `eng_start_o` is high during the cycle after acceptance. `eng_done_i` is sampled only after that start cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| card_busy_i | input | 1 | Card signals busy on its data line |
| eng_start_o | output | 1 | One-cycle start pulse to the bus engine |
| eng_index_o | output | 6 | Command index of the active command |
| eng_arg_o | output | 32 | Argument of the active command |
| eng_resp_o | output | 1 | Active command expects a response |
| eng_long_o | output | 1 | Active command expects a long response |
| eng_init_o | output | 1 | Send the initialization sequence first |
| eng_done_i | input | 1 | Engine has finished the command |
| eng_timeout_i | input | 1 | Response timeout, valid with done |
| eng_crc_err_i | input | 1 | Response CRC mismatch, valid with done |
| eng_start_err_i | input | 1 | Start-bit error, valid with done |
| eng_end_err_i | input | 1 | End-bit error, valid with done |
| eng_resp_err_i | input | 1 | Response content error, valid with done |
| eng_resp_i | input | 128 | Received response, least significant word in bits [31:0] |
| card_clk_en_o | output | 1 | Card clock enable in use |
| card_clk_div_o | output | 8 | Card clock divider in use |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can act on the raw interrupt status in the same cycle: software's write-one-to-clear, and the engine's completion, which sets bits. The bench provokes the collision by leaving bits 2 and 6 set from an earlier command. It then drives `eng_done_i` and a clear of exactly those bits in the same cycle. It expects bit 6 to be gone and bit 2 to remain. A second overlap is a command-register write that arrives while a data command is held back by card busy. The bench judges it by reading the command word back unchanged, and by the later start carrying the original index and argument.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;

  localparam logic [ADDR_W-1:0] A_GCTL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CLK   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ARG   = 4'd3;
  localparam logic [ADDR_W-1:0] A_RESP0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd10;

  localparam int C_RESP = 6;
  localparam int C_LONG = 7;
  localparam int C_CRC  = 8;
  localparam int C_DATA = 9;
  localparam int C_INIT = 15;
  localparam int C_UPD  = 21;
  localparam int C_LOAD = 31;

  localparam int G_IRQ_EN = 4;
  localparam int K_EN     = 16;

  localparam int S_RERR = 1;
  localparam int S_DONE = 2;
  localparam int S_RCRC = 6;
  localparam int S_RTO  = 8;
  localparam int S_SBE  = 13;
  localparam int S_EBE  = 15;

  localparam int T_BUSY = 9;
  localparam int T_FSM  = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} issue_st_e;

  typedef struct packed {
    logic resp_err;
    logic end_err;
    logic start_err;
    logic crc_err;
    logic timeout;
  } eng_err_t;

  typedef struct packed {
    logic [5:0] index;
    logic       resp;
    logic       long_r;
    logic       crc;
    logic       init;
  } act_cmd_t;
endpackage

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pend_i,
  input  logic      upd_i,
  input  logic      data_i,
  input  logic      busy_i,
  input  logic      done_i,
  output logic      accept_o,
  output logic      clk_apply_o,
  output logic      cap_o,
  output logic      start_o,
  output issue_st_e st_o
);
  issue_st_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    accept_o    = 1'b0;
    clk_apply_o = 1'b0;
    cap_o       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_i) begin
          if (upd_i) begin
            accept_o    = 1'b1;
            clk_apply_o = 1'b1;
          end else if (!(data_i && busy_i)) begin
            accept_o = 1'b1;
            st_d     = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (done_i) begin
          cap_o = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign start_o = (st_q == ST_ISSUE);
  assign st_o    = st_q;
endmodule

// File: rtl/sd_cmd_resp.sv
module sd_cmd_resp
  import sd_cmd_pkg::*;
#(
  parameter int RESP_WORDS = 4,
  localparam int RESP_W    = RESP_WORDS * REG_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cap_i,
  input  logic                             resp_i,
  input  logic                             long_i,
  input  logic                             crc_chk_i,
  input  eng_err_t                         err_i,
  input  logic [RESP_W-1:0]                data_i,
  input  logic                             clr_we_i,
  input  logic [REG_W-1:0]                 clr_i,
  output logic [RESP_WORDS-1:0][REG_W-1:0] resp_o,
  output logic [REG_W-1:0]                 raw_o
);
  logic [REG_W-1:0] set_v, clr_v, raw_q;

  for (genvar g = 0; g < RESP_WORDS; g++) begin : g_word
    logic wr_en;
    if (g == 0) begin : g_first
      assign wr_en = cap_i && resp_i;
    end else begin : g_upper
      assign wr_en = cap_i && resp_i && long_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    resp_o[g] <= '0;
      else if (wr_en) resp_o[g] <= data_i[g*REG_W +: REG_W];
    end
  end

  always_comb begin
    set_v = '0;
    if (cap_i) begin
      set_v[S_DONE] = 1'b1;
      set_v[S_RTO]  = err_i.timeout;
      set_v[S_RCRC] = err_i.crc_err && crc_chk_i;
      set_v[S_SBE]  = err_i.start_err;
      set_v[S_EBE]  = err_i.end_err;
      set_v[S_RERR] = err_i.resp_err;
    end
    clr_v = clr_we_i ? clr_i : '0;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_v) | set_v;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/sd_clk_upd.sv
module sd_clk_upd #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             en_o,
  output logic [DIV_W-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      div_o <= '0;
    end else if (apply_i) begin
      en_o  <= en_i;
      div_o <= div_i;
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int RESP_WORDS = 4,
  parameter int DIV_W      = 8,
  localparam int RESP_W    = RESP_WORDS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              card_busy_i,
  output logic              eng_start_o,
  output logic [5:0]        eng_index_o,
  output logic [REG_W-1:0]  eng_arg_o,
  output logic              eng_resp_o,
  output logic              eng_long_o,
  output logic              eng_init_o,
  input  logic              eng_done_i,
  input  logic              eng_timeout_i,
  input  logic              eng_crc_err_i,
  input  logic              eng_start_err_i,
  input  logic              eng_end_err_i,
  input  logic              eng_resp_err_i,
  input  logic [RESP_W-1:0] eng_resp_i,
  output logic              card_clk_en_o,
  output logic [DIV_W-1:0]  card_clk_div_o,
  output logic              irq_o
);
  logic [REG_W-1:0] gctl_q, clk_q, cmd_q, arg_q, mask_q, raw;
  logic [REG_W-1:0] act_arg_q, stat;
  logic [RESP_WORDS-1:0][REG_W-1:0] resp;
  act_cmd_t  act_q;
  eng_err_t  err;
  issue_st_e st;
  logic accept, clk_apply, cap;

  function automatic logic wr_hit(input logic [ADDR_W-1:0] a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q <= '0;
      clk_q  <= '0;
      arg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_hit(A_GCTL)) gctl_q <= reg_wdata_i;
      if (wr_hit(A_CLK))  clk_q  <= reg_wdata_i;
      if (wr_hit(A_ARG))  arg_q  <= reg_wdata_i;
      if (wr_hit(A_MASK)) mask_q <= reg_wdata_i;
    end
  end

  // command word locked while load bit pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cmd_q         <= '0;
    else if (wr_hit(A_CMD) && !cmd_q[C_LOAD]) cmd_q     <= reg_wdata_i;
    else if (accept)                      cmd_q[C_LOAD] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      act_arg_q <= '0;
    end else if (accept && !cmd_q[C_UPD]) begin
      act_q.index  <= cmd_q[5:0];
      act_q.resp   <= cmd_q[C_RESP];
      act_q.long_r <= cmd_q[C_LONG];
      act_q.crc    <= cmd_q[C_CRC];
      act_q.init   <= cmd_q[C_INIT];
      act_arg_q    <= arg_q;
    end
  end

  sd_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (cmd_q[C_LOAD]),
    .upd_i       (cmd_q[C_UPD]),
    .data_i      (cmd_q[C_DATA]),
    .busy_i      (card_busy_i),
    .done_i      (eng_done_i),
    .accept_o    (accept),
    .clk_apply_o (clk_apply),
    .cap_o       (cap),
    .start_o     (eng_start_o),
    .st_o        (st)
  );

  assign err = '{resp_err:  eng_resp_err_i,
                 end_err:   eng_end_err_i,
                 start_err: eng_start_err_i,
                 crc_err:   eng_crc_err_i,
                 timeout:   eng_timeout_i};

  sd_cmd_resp #(.RESP_WORDS(RESP_WORDS)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .resp_i    (act_q.resp),
    .long_i    (act_q.long_r),
    .crc_chk_i (act_q.crc),
    .err_i     (err),
    .data_i    (eng_resp_i),
    .clr_we_i  (wr_hit(A_RAW)),
    .clr_i     (reg_wdata_i),
    .resp_o    (resp),
    .raw_o     (raw)
  );

  sd_clk_upd #(.DIV_W(DIV_W)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .apply_i (clk_apply),
    .en_i    (clk_q[K_EN]),
    .div_i   (clk_q[DIV_W-1:0]),
    .en_o    (card_clk_en_o),
    .div_o   (card_clk_div_o)
  );

  always_comb begin
    stat         = '0;
    stat[T_BUSY] = card_busy_i;
    stat[T_FSM]  = (st != ST_IDLE);
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_GCTL:  reg_rdata_o = gctl_q;
      A_CLK:   reg_rdata_o = clk_q;
      A_CMD:   reg_rdata_o = cmd_q;
      A_ARG:   reg_rdata_o = arg_q;
      A_MASK:  reg_rdata_o = mask_q;
      A_RAW:   reg_rdata_o = raw;
      A_STAT:  reg_rdata_o = stat;
      default: reg_rdata_o = '0;
    endcase
    for (int i = 0; i < RESP_WORDS; i++) begin
      if (reg_addr_i == ADDR_W'(int'(A_RESP0) + i)) reg_rdata_o = resp[i];
    end
  end

  assign eng_index_o = act_q.index;
  assign eng_arg_o   = act_arg_q;
  assign eng_resp_o  = act_q.resp;
  assign eng_long_o  = act_q.long_r;
  assign eng_init_o  = act_q.init;
  assign irq_o       = gctl_q[G_IRQ_EN] && |(raw & mask_q);
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        eng_start_o,
  input logic        card_busy_i,
  input logic [31:0] cmd_q,
  input logic        accept,
  input logic        clk_apply,
  input logic        cap,
  input logic        card_clk_en_o,
  input logic [7:0]  card_clk_div_o,
  input logic [31:0] gctl_q,
  input logic [31:0] raw,
  input logic        irq_o
);
  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_pending_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q[31] && !accept) |=> (cmd_q == $past(cmd_q)));

  p_update_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_apply |=> !eng_start_o);

  p_clk_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_apply |=> ($stable(card_clk_en_o) && $stable(card_clk_div_o)));

  p_busy_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && cmd_q[9]) |-> !$past(card_busy_i));

  p_done_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> raw[2]);

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gctl_q[4] |-> !irq_o);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .eng_start_o    (eng_start_o),
  .card_busy_i    (card_busy_i),
  .cmd_q          (cmd_q),
  .accept         (accept),
  .clk_apply      (clk_apply),
  .cap            (cap),
  .card_clk_en_o  (card_clk_en_o),
  .card_clk_div_o (card_clk_div_o),
  .gctl_q         (gctl_q),
  .raw            (raw),
  .irq_o          (irq_o)
);

// File: tb/sd_cmd_issue_tb_top.sv
module sd_cmd_issue_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 7;

  // {cmd, resp_lo, err[4:0]=resp,end,start,crc,timeout, exp_raw, exp_resp0}
  localparam logic [132:0] VEC [NV] = '{
    {32'h8000_8000, 32'h1111_1111, 5'b00000, 32'h0000_0004, 32'h0000_0000},
    {32'h8000_0151, 32'hA5A5_0001, 5'b00000, 32'h0000_0004, 32'hA5A5_0001},
    {32'h8000_0069, 32'h00FF_8000, 5'b00010, 32'h0000_0004, 32'h00FF_8000},
    {32'h8000_0151, 32'h1234_5678, 5'b00010, 32'h0000_0044, 32'h1234_5678},
    {32'h8000_0148, 32'hDEAD_0000, 5'b00001, 32'h0000_0104, 32'hDEAD_0000},
    {32'h8000_0141, 32'h0BAD_0001, 5'b01100, 32'h0000_A004, 32'h0BAD_0001},
    {32'h8000_0142, 32'h0000_0006, 5'b10000, 32'h0000_0006, 32'h0000_0006}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         busy = 1'b0;
  logic         start;
  logic [5:0]   idx;
  logic [31:0]  arg;
  logic         e_resp, e_long, e_init;
  logic         done = 1'b0;
  logic [4:0]   errs = '0;
  logic [127:0] rsp = '0;
  logic         ck_en, irq;
  logic [7:0]   ck_div;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_issue dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .card_busy_i(busy),
    .eng_start_o(start), .eng_index_o(idx), .eng_arg_o(arg),
    .eng_resp_o(e_resp), .eng_long_o(e_long), .eng_init_o(e_init),
    .eng_done_i(done), .eng_timeout_i(errs[0]), .eng_crc_err_i(errs[1]),
    .eng_start_err_i(errs[2]), .eng_end_err_i(errs[3]), .eng_resp_err_i(errs[4]),
    .eng_resp_i(rsp),
    .card_clk_en_o(ck_en), .card_clk_div_o(ck_div), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_start(input string req, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (start) seen = 1'b1;
    end
    chk(req, {31'd0, seen}, 32'd1);
  endtask

  // issue, wait for start, then finish with errors and response data
  task automatic run_cmd(input logic [31:0] cmd, input logic [4:0] e,
                         input logic [127:0] r, input bit clr_en,
                         input logic [31:0] clr_val);
    bit seen;
    wr(4'd2, cmd);
    wait_start("R1 start", seen);
    chk("R1 index", {26'd0, idx}, {26'd0, cmd[5:0]});
    @(negedge clk);
    chk("R1 pulse width", {31'd0, start}, 32'd0);
    done = 1'b1; errs = e; rsp = r;
    if (clr_en) begin we = 1'b1; addr = 4'd9; wdata = clr_val; end
    @(negedge clk);
    done = 1'b0; errs = '0; we = 1'b0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    // reset state
    rd(4'd9, v); chk("R9 reset raw", v, 0);
    rd(4'd2, v); chk("R1 reset cmd", v, 0);
    chk("R10 reset irq", {31'd0, irq}, 0);
    chk("R3 reset clk_en", {31'd0, ck_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven commands
    for (int i = 0; i < NV; i++) begin
      wr(4'd9, 32'hFFFF_FFFF);
      run_cmd(VEC[i][132:101], VEC[i][68:64], {96'd0, VEC[i][100:69]}, 1'b0, 0);
      rd(4'd9, v); chk("R7/R8 raw status", v, VEC[i][63:32]);
      rd(4'd4, v); chk("R6 resp0", v, VEC[i][31:0]);
      rd(4'd2, v); chk("R1 load cleared", {31'd0, v[31]}, 0);
    end

    // long response
    run_cmd(32'h8000_01C2, 5'd0,
            {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 1'b0, 0);
    chk("R6 long flag", {31'd0, e_long}, 1);
    rd(4'd4, v); chk("R6 long w0", v, 32'h1111_1111);
    rd(4'd5, v); chk("R6 long w1", v, 32'h2222_2222);
    rd(4'd7, v); chk("R6 long w3", v, 32'h4444_4444);
    run_cmd(32'h8000_0151, 5'd0, {96'hFFFF_FFFF_EEEE_EEEE_DDDD_DDDD, 32'h5555_5555}, 1'b0, 0);
    rd(4'd5, v); chk("R6 short keeps w1", v, 32'h2222_2222);
    rd(4'd4, v); chk("R6 short w0", v, 32'h5555_5555);

    // clock update
    wr(4'd1, 32'h0001_0005);
    repeat (2) @(negedge clk);
    chk("R4 en not applied", {31'd0, ck_en}, 0);
    chk("R4 div not applied", {24'd0, ck_div}, 0);
    wr(4'd2, 32'h8020_0000);
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); if (start) seen = 1'b1; end
    chk("R3 no engine start", {31'd0, seen}, 0);
    chk("R3 en applied", {31'd0, ck_en}, 1);
    chk("R3 div applied", {24'd0, ck_div}, 5);
    rd(4'd2, v); chk("R3 load cleared", {31'd0, v[31]}, 0);

    // busy hold and ignored rewrite
    busy = 1'b1;
    rd(4'd10, v); chk("R5 status busy", {31'd0, v[9]}, 1);
    wr(4'd3, 32'hCAFE_0001);
    wr(4'd2, 32'h8000_2251);
    seen = 1'b0;
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (start) seen = 1'b1; end
    chk("R5 held while busy", {31'd0, seen}, 0);
    wr(4'd2, 32'h8000_0148);
    rd(4'd2, v); chk("R2 pending unchanged", v, 32'h8000_2251);
    busy = 1'b0;
    wait_start("R5 start after busy", seen);
    chk("R5 index", {26'd0, idx}, 32'h11);
    chk("R1 argument", arg, 32'hCAFE_0001);
    @(negedge clk);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // interrupt gating
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd8, 32'h0000_0004);
    run_cmd(32'h8000_0151, 5'd0, 128'd0, 1'b0, 0);
    chk("R10 gated off", {31'd0, irq}, 0);
    wr(4'd0, 32'h0000_0010);
    chk("R10 enabled", {31'd0, irq}, 1);
    wr(4'd8, 32'h0000_0100);
    chk("R10 masked", {31'd0, irq}, 0);
    wr(4'd8, 32'h0000_0004);
    wr(4'd9, 32'h0000_0004);
    chk("R9 clear drops irq", {31'd0, irq}, 0);

    // clear and set in the same cycle
    run_cmd(32'h8000_0151, 5'b00010, 128'd0, 1'b0, 0);
    rd(4'd9, v); chk("R8 crc flagged", v, 32'h44);
    run_cmd(32'h8000_0151, 5'd0, 128'd0, 1'b1, 32'h44);
    rd(4'd9, v); chk("R9 set wins", v, 32'h4);

    finish_up();
  end
endmodule